// File: doc/BRIEF.md
# Memory Protection Region Register File

This block stores the protection settings for a set of memory regions (16 by default). Each region has an 8-bit settings byte and a 32-bit address word. A single CSR-style port reaches all of them. It carries a register index, a write enable, write data and a read data return. Four settings bytes share one 32-bit settings register, and each address word has a register of its own. A downstream access checker reads every region's settings byte and address word from two wide output buses.

The block enforces the lock rules itself. A region whose lock bit is set accepts no further change to its settings byte or to its address word. A locked top-of-range region also protects the address word of the region below it, because that word forms the base of its range. Illegal settings are changed before they are stored. Software can therefore write a value, read it back and see whether it was accepted. Only reset clears a lock.

Register index map with 16 regions: indexes 0 to 3 are the packed settings registers. Indexes 16 to 31 are the address words of regions 0 to 15. Every other index is unused.

Top module: `pmp_reg_file`

## Requirements
- R1: Reset clears every settings byte and every address word, so all reads and both output buses return zero after reset. A lock bit set before reset is gone after reset.
- R2: Region r occupies settings register index r/4, at bit offset (r mod 4)*8 of that register, on both the read port and the write port.
- R3: Settings byte layout: bit 0 read permission, bit 1 write permission, bit 2 execute permission, bits 4:3 match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. Bits 6:5 always read as zero, whatever was written to them.
- R4: A write that sets the write permission (bit 1) while the read permission (bit 0) is clear stores the byte with bit 1 cleared. The other fields are stored as written.
- R5: A write to a settings register changes only the bytes of unlocked regions. The byte of a locked region keeps its value, while its unlocked neighbours in the same register update.
- R6: Writes to the address word of a locked region are ignored.
- R7: If region i+1 is locked and its mode is top-of-range (1), writes to the address word of region i are ignored. If region i+1 is locked in any other mode, the address word of region i stays writable.
- R8: The address word of region r sits at index 16+r. All 32 bits are stored as written and read back unchanged.
- R9: A write is visible on the read port and on the output buses from the clock edge that takes the write onwards. The read port is combinational from the stored state. The settings bus carries region r at bits r*8+7:r*8, and the address bus carries region r at bits r*32+31:r*32.
- R10: An unused index reads as zero, and a write to it changes no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_idx_i | input | 5 | Register index for reads and writes |
| csr_we_i | input | 1 | Write enable for the indexed register |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data of the indexed register |
| region_cfg_o | output | 128 | Settings byte of every region, region r at bits r*8+7:r*8 |
| region_addr_o | output | 512 | Address word of every region, region r at bits r*32+31:r*32 |

## Verification
The stimulus writes settings words that mix legal bytes with bytes carrying the reserved write-without-read pair and set reserved bits. Read-back then shows whether legalisation acts on each byte on its own. In a settings register that holds one locked byte, a write of all zeros separates per-byte masking from a blocking of the whole register. Address writes are aimed at a locked region, at the region below a locked top-of-range region, and at the region below a locked region in off mode. Together they separate the three cases of the lock rule. A reset in the middle of the run, followed by an address write to the formerly locked region, shows that reset is the only thing that clears a lock.

// File: rtl/pmp_reg_pkg.sv
package pmp_reg_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_FOUR  = 2'd2,
        MATCH_POW2  = 2'd3
    } match_mode_e;

    // One region settings byte, most significant field first.
    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } region_cfg_t;

    localparam int unsigned CFG_BYTE_W   = 8;
    localparam int unsigned BYTES_PER_REG = 4;

endpackage

// File: rtl/pmp_cfg_legalize.sv
module pmp_cfg_legalize
    import pmp_reg_pkg::*;
(
    input  region_cfg_t raw_i,
    output region_cfg_t legal_o
);
    always_comb begin
        legal_o      = raw_i;
        legal_o.rsvd = 2'b00;
        legal_o.w    = raw_i.w & raw_i.r;   // write without read is reserved
    end
endmodule

// File: rtl/pmp_lock_eval.sv
module pmp_lock_eval #(
    parameter int unsigned NUM_REGIONS = 16
) (
    input  logic [NUM_REGIONS-1:0] lock_i,
    input  logic [NUM_REGIONS-1:0] tor_i,
    output logic [NUM_REGIONS-1:0] cfg_open_o,
    output logic [NUM_REGIONS-1:0] addr_open_o
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        assign cfg_open_o[i] = ~lock_i[i];
        if (i < NUM_REGIONS - 1) begin : g_has_upper
            // A locked top-of-range region above uses this word as its base.
            assign addr_open_o[i] = ~lock_i[i] & ~(lock_i[i+1] & tor_i[i+1]);
        end else begin : g_top
            assign addr_open_o[i] = ~lock_i[i];
        end
    end
endmodule

// File: rtl/pmp_reg_file.sv
module pmp_reg_file
    import pmp_reg_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned ADDR_W      = 32,
    localparam int unsigned IDX_W      = $clog2(2 * NUM_REGIONS)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [IDX_W-1:0]              csr_idx_i,
    input  logic                          csr_we_i,
    input  logic [ADDR_W-1:0]             csr_wdata_i,
    output logic [ADDR_W-1:0]             csr_rdata_o,
    output logic [NUM_REGIONS*8-1:0]      region_cfg_o,
    output logic [NUM_REGIONS*ADDR_W-1:0] region_addr_o
);
    localparam int unsigned CFG_REGS  = NUM_REGIONS / BYTES_PER_REG;
    localparam int unsigned ADDR_BASE = NUM_REGIONS;

    typedef struct packed {
        logic [NUM_REGIONS-1:0][CFG_BYTE_W-1:0] cfg;
        logic [NUM_REGIONS-1:0][ADDR_W-1:0]     addr;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_REGIONS-1:0] lock_vec, tor_vec;
    logic [NUM_REGIONS-1:0] cfg_open, addr_open;
    logic [NUM_REGIONS-1:0][CFG_BYTE_W-1:0] legal_byte;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        region_cfg_t cur_cfg, raw_cfg, leg_cfg;
        assign cur_cfg     = region_cfg_t'(state_q.cfg[r]);
        assign lock_vec[r] = cur_cfg.lock;
        assign tor_vec[r]  = (cur_cfg.mode == MATCH_TOR);
        assign raw_cfg     = region_cfg_t'(csr_wdata_i[(r % BYTES_PER_REG)*CFG_BYTE_W +: CFG_BYTE_W]);
        assign legal_byte[r] = leg_cfg;

        pmp_cfg_legalize u_legal (
            .raw_i   (raw_cfg),
            .legal_o (leg_cfg)
        );

        assign region_cfg_o[r*CFG_BYTE_W +: CFG_BYTE_W] = state_q.cfg[r];
        assign region_addr_o[r*ADDR_W +: ADDR_W]        = state_q.addr[r];
    end

    pmp_lock_eval #(.NUM_REGIONS(NUM_REGIONS)) u_lock (
        .lock_i      (lock_vec),
        .tor_i       (tor_vec),
        .cfg_open_o  (cfg_open),
        .addr_open_o (addr_open)
    );

    always_comb begin
        state_d = state_q;
        if (csr_we_i) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (int'(csr_idx_i) == r / BYTES_PER_REG && cfg_open[r]) begin
                    state_d.cfg[r] = legal_byte[r];
                end
                if (int'(csr_idx_i) == ADDR_BASE + r && addr_open[r]) begin
                    state_d.addr[r] = csr_wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        csr_rdata_o = '0;
        for (int c = 0; c < CFG_REGS; c++) begin
            if (int'(csr_idx_i) == c) begin
                for (int b = 0; b < BYTES_PER_REG; b++) begin
                    csr_rdata_o[b*CFG_BYTE_W +: CFG_BYTE_W] = state_q.cfg[c*BYTES_PER_REG + b];
                end
            end
        end
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (int'(csr_idx_i) == ADDR_BASE + r) begin
                csr_rdata_o = state_q.addr[r];
            end
        end
    end

endmodule

// File: rtl/pmp_reg_file_chk.sv
module pmp_reg_file_chk #(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned ADDR_W      = 32
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [NUM_REGIONS*8-1:0]      region_cfg_o,
    input logic [NUM_REGIONS*ADDR_W-1:0] region_addr_o
);
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (region_cfg_o == '0 && region_addr_o == '0));

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_chk
        assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            region_cfg_o[i*8+6 -: 2] == 2'b00);

        assert_w_needs_r_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            region_cfg_o[i*8+1] |-> region_cfg_o[i*8]);

        assert_locked_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            region_cfg_o[i*8+7] |=> $stable(region_cfg_o[i*8 +: 8]));

        assert_locked_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            region_cfg_o[i*8+7] |=> $stable(region_addr_o[i*ADDR_W +: ADDR_W]));

        if (i < NUM_REGIONS - 1) begin : g_tor
            assert_tor_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (region_cfg_o[(i+1)*8+7] && region_cfg_o[(i+1)*8+4 -: 2] == 2'd1)
                |=> $stable(region_addr_o[i*ADDR_W +: ADDR_W]));
        end
    end
endmodule

bind pmp_reg_file pmp_reg_file_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .region_cfg_o  (region_cfg_o),
    .region_addr_o (region_addr_o)
);

// File: tb/pmp_reg_file_test.sv
module pmp_reg_file_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        csr_idx = '0;
    logic              csr_we = 1'b0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic [NR*8-1:0]   region_cfg;
    logic [NR*32-1:0]  region_addr;

    pmp_reg_file uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .csr_idx_i     (csr_idx),
        .csr_we_i      (csr_we),
        .csr_wdata_i   (csr_wdata),
        .csr_rdata_o   (csr_rdata),
        .region_cfg_o  (region_cfg),
        .region_addr_o (region_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          kind;   // 0 read port, 1 settings bus byte, 2 address bus word
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Monitor: compares the oldest expected item against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                case (it.kind)
                    0: got = csr_rdata;
                    1: got = {24'h0, region_cfg[it.sel*8 +: 8]};
                    default: got = region_addr[it.sel*32 +: 32];
                endcase
                n_checks++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d sel=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input int idx, input logic [31:0] d);
        @(posedge clk); #1;
        csr_we = 1'b1; csr_idx = 5'(idx); csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 1'b0;
    endtask

    task automatic expect_item(input int kind, input int sel, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        csr_we = 1'b0;
        if (kind == 0) csr_idx = 5'(sel);
        it.kind = kind; it.sel = sel; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state, still in reset
        expect_item(0, 0, 32'h0, "R1 cfg reg0 in reset");
        expect_item(0, 3, 32'h0, "R1 cfg reg3 in reset");
        expect_item(0, 16, 32'h0, "R1 addr region0 in reset");
        rst_n = 1'b1;
        expect_item(2, 15, 32'h0, "R1 addr bus region15");

        // R8 / R9: address word round trip
        wr(21, 32'hDEADBEEF);
        expect_item(0, 21, 32'hDEADBEEF, "R8 addr region5 readback");
        expect_item(2, 5, 32'hDEADBEEF, "R9 addr bus region5");

        // R3 / R4: legalisation per byte in settings register 1
        wr(1, 32'h7EE20B19);
        expect_item(0, 1, 32'h1C800B19, "R3 R4 cfg reg1 legalised");
        expect_item(1, 6, 32'h80, "R4 region6 lock only");
        expect_item(1, 7, 32'h1C, "R3 region7 reserved cleared");
        expect_item(1, 4, 32'h19, "R9 region4 on bus");

        // R5: locked byte keeps value, neighbours clear
        wr(1, 32'h00000000);
        expect_item(0, 1, 32'h00800000, "R5 locked byte kept");

        // R6: locked region address ignored; R7 negative case (region6 mode off)
        wr(22, 32'h12345678);
        expect_item(0, 22, 32'h0, "R6 locked region6 addr");
        wr(21, 32'h00001111);
        expect_item(0, 21, 32'h00001111, "R7 off-mode lock leaves region5 open");

        // R7: locked top-of-range region9 guards region8
        wr(24, 32'hAAAA0000);
        wr(25, 32'h00005555);
        wr(2, 32'h00008900);
        expect_item(1, 9, 32'h89, "R2 region9 byte1 of reg2");
        wr(24, 32'h00000001);
        expect_item(0, 24, 32'hAAAA0000, "R7 region8 base guarded");
        wr(25, 32'h00000002);
        expect_item(0, 25, 32'h00005555, "R6 region9 addr locked");
        wr(26, 32'h00000077);
        expect_item(0, 26, 32'h00000077, "R7 region10 unaffected");

        // R2: byte positions in settings register 3
        wr(3, 32'h01020304);
        expect_item(0, 3, 32'h01000304, "R2 R4 cfg reg3");
        expect_item(1, 12, 32'h04, "R2 region12");
        expect_item(1, 14, 32'h00, "R2 R4 region14");
        expect_item(1, 15, 32'h01, "R2 region15");

        // R10: unused index
        wr(7, 32'hFFFFFFFF);
        expect_item(0, 7, 32'h0, "R10 unused reads zero");
        expect_item(0, 0, 32'h0, "R10 cfg reg0 untouched");
        expect_item(0, 2, 32'h00008900, "R10 cfg reg2 untouched");

        // R8: top address word full width
        wr(31, 32'hFFFFFFFF);
        expect_item(0, 31, 32'hFFFFFFFF, "R8 addr region15");

        // R1: reset mid-run clears locks
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_item(0, 1, 32'h0, "R1 cfg reg1 after reset");
        expect_item(0, 24, 32'h0, "R1 addr region8 after reset");
        wr(22, 32'h00000ABC);
        expect_item(0, 22, 32'h00000ABC, "R1 lock cleared by reset");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule